// File: doc/BRIEF.md
# CD Sector Buffer Transfer Engine

This block drains decoded sector data out of a byte-wide sector buffer. Software arms a transfer with a 16-bit buffer byte address and a 16-bit byte counter. The data then leaves the buffer in one of two ways. In the first, a host processor pulls one word per read strobe. In the second, a DMA step copies a chunk of words into a word-addressed RAM at one word per clock. Every word is packed big-endian: the byte at the current buffer address forms the upper half and the byte after it forms the lower half.

Both paths share one end-of-transfer unit. When the counter runs out, that unit drops the busy state and updates the status flags. If interface control allows it, it also clears the pending-end status bit and pulses the interrupt. Where a DMA word lands depends on the 3-bit destination code, the DMA address and the word RAM mode. Program RAM and whole word RAM take consecutive words. Split word RAM interleaves words by bank.

Top module: `cdx_xfer_engine`

## Requirements
- R1: After reset, busy_o=0, xfer_cnt_o=0, irq_o=0, end_flag_o=0, data_rdy_o=0, dst_we_o=0, host_data_o=0 and if_stat_o=8'hFF.
- R2: start_i with xfer_en_i=1 loads the address and counter and sets busy_o=1, data_rdy_o=1, end_flag_o=0 and if_stat_o[3]=0. With xfer_en_i=0, start_i changes nothing.
- R3: An accepted host read returns {buf[a], buf[(a+1) mod 65536]} on host_data_o in the following cycle. The address then advances by 2 modulo 65536.
- R4: A host read is accepted only while busy and no DMA step is running, with dest_sel_i=3 for host_is_sub_i=1 or dest_sel_i=2 for host_is_sub_i=0. A rejected read returns 0 and leaves the address and counter unchanged.
- R5: An accepted host read lowers the counter by 2. When the counter was 2 or less, the transfer ends and the counter becomes 0. The counter is 0 whenever the engine is idle.
- R6: When a transfer ends, busy_o=0, end_flag_o=1, data_rdy_o=0 and if_stat_o[3]=1. If end_irq_en_i=1, if_stat_o[6] is also cleared, and irq_o pulses for one cycle when irq_mask_i=1.
- R7: A DMA step with counter c moves 256 words when c>512. Otherwise it is the last step and moves (c+1)>>1 words.
- R8: After a DMA step of w words, the address grows by 2w modulo 65536. The counter drops by 2w, or becomes 0 if the step was the last.
- R9: Destination code 5 writes to byte offset dma_addr*8+2k. Code 7 with ram_1m_i=0 writes to (dma_addr & 0x7FFF)*8+2k, where k is the word index.
- R10: Code 7 with ram_1m_i=1 writes to (dma_addr & 0x3FFF)*16+4k, plus 2 when bank_i=0.
- R11: Any other destination code writes nothing, but still advances the address and counter and can end the transfer.
- R12: DMA writes one word per clock right after dma_go_i is taken. dma_done_o rises in the cycle after the last write, or in the first cycle for a non-writing step.
- R13: irq_ack_i sets if_stat_o[6]. When an ack arrives in the same cycle as an end with end_irq_en_i=1, the end wins and the bit stays clear.
- R14: Dropping xfer_en_i while busy stops the transfer. busy_o and the counter become 0 and if_stat_o[3]=1, and end_flag_o and irq_o are left alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_en_i | input | 1 | Transfer enable; low aborts |
| start_i | input | 1 | Arm a transfer |
| start_addr_i | input | 16 | Initial buffer byte address |
| start_cnt_i | input | 16 | Initial byte counter |
| dest_sel_i | input | 3 | Destination code |
| dma_addr_i | input | 16 | DMA destination address |
| ram_1m_i | input | 1 | Word RAM split into two banks |
| bank_i | input | 1 | Selected bank in split mode |
| end_irq_en_i | input | 1 | End interrupt enable |
| irq_mask_i | input | 1 | Interrupt line mask |
| irq_ack_i | input | 1 | Acknowledge end interrupt |
| host_rd_i | input | 1 | Host word read strobe |
| host_is_sub_i | input | 1 | Read issued by sub processor |
| host_data_o | output | 16 | Host read data |
| dma_go_i | input | 1 | Start one DMA step |
| dma_done_o | output | 1 | DMA step complete |
| buf_addr_o | output | 16 | Buffer byte address |
| buf_hi_i | input | 8 | Buffer byte at buf_addr_o |
| buf_lo_i | input | 8 | Buffer byte at buf_addr_o+1 |
| dst_we_o | output | 1 | Destination write enable |
| dst_addr_o | output | 20 | Destination byte offset |
| dst_data_o | output | 16 | Destination write data |
| busy_o | output | 1 | Transfer in progress |
| xfer_addr_o | output | 16 | Current buffer address |
| xfer_cnt_o | output | 16 | Current byte counter |
| end_flag_o | output | 1 | Transfer ended |
| data_rdy_o | output | 1 | Data ready |
| if_stat_o | output | 8 | Interface status (bit 3 idle, bit 6 end pending when low) |
| irq_o | output | 1 | End interrupt pulse |

## Verification
An interrupt acknowledge and a transfer end can both touch if_stat_o[6] in the same cycle. The bench provokes this by asserting irq_ack_i in the same cycle as the final host read of an interrupt-enabled transfer. It then judges that the bit stays clear and that irq_o still pulses, and it checks that a later lone acknowledge sets the bit again. Around this case, the bench sweeps the DMA path over six destination settings and nine counter values, and checks every written word against offsets and data computed arithmetically.

// File: rtl/cdx_xfer_pkg.sv
package cdx_xfer_pkg;
  localparam logic [2:0] DST_MAIN  = 3'd2;
  localparam logic [2:0] DST_SUB   = 3'd3;
  localparam logic [2:0] DST_AUDIO = 3'd4;
  localparam logic [2:0] DST_PRG   = 3'd5;
  localparam logic [2:0] DST_WORD  = 3'd7;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;
endpackage

// File: rtl/cdx_dest_map.sv
module cdx_dest_map
  import cdx_xfer_pkg::*;
#(
  parameter int DMA_AW = 16,
  parameter int OFF_W  = 20
) (
  input  logic [2:0]        dest_sel_i,
  input  logic              ram_1m_i,
  input  logic              bank_i,
  input  logic [DMA_AW-1:0] dma_addr_i,
  output logic [OFF_W-1:0]  base_off_o,
  output logic              stride4_o,
  output logic              wr_en_o
);
  localparam logic [DMA_AW-1:0] MASK_2M = DMA_AW'(16'h7FFF);
  localparam logic [DMA_AW-1:0] MASK_1M = DMA_AW'(16'h3FFF);

  always_comb begin
    base_off_o = '0;
    stride4_o  = 1'b0;
    wr_en_o    = 1'b0;
    unique case (dest_sel_i)
      DST_PRG: begin
        wr_en_o    = 1'b1;
        base_off_o = OFF_W'(dma_addr_i) << 3;
      end
      DST_WORD: begin
        wr_en_o = 1'b1;
        if (ram_1m_i) begin
          stride4_o  = 1'b1;
          base_off_o = (OFF_W'(dma_addr_i & MASK_1M) << 4)
                     + (bank_i ? OFF_W'(0) : OFF_W'(2));
        end else begin
          base_off_o = OFF_W'(dma_addr_i & MASK_2M) << 3;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cdx_dma_seq.sv
module cdx_dma_seq
  import cdx_xfer_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CW          = 16,
  parameter int OFF_W       = 20,
  parameter int CHUNK_WORDS = 256,
  localparam int WC_W       = $clog2(CHUNK_WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             abort_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [AW-1:0]    src_i,
  input  logic [OFF_W-1:0] base_off_i,
  input  logic             stride4_i,
  input  logic             wr_en_i,
  input  logic [7:0]       buf_hi_i,
  input  logic [7:0]       buf_lo_i,
  output logic             run_o,
  output logic             last_o,
  output logic [WC_W-1:0]  words_o,
  output logic [AW-1:0]    src_addr_o,
  output logic             we_o,
  output logic [OFF_W-1:0] waddr_o,
  output logic [15:0]      wdata_o,
  output logic             done_o
);
  localparam int LAST_LIM = 2 * CHUNK_WORDS;

  seq_state_e        state_q;
  logic [WC_W-1:0]   rem_q, words_q;
  logic              last_q, stride4_q, wr_q;
  logic [AW-1:0]     src_q;
  logic [OFF_W-1:0]  off_q;

  logic              go_last;
  logic [CW:0]       go_half;
  logic [WC_W-1:0]   go_words;

  assign go_last  = cnt_i <= CW'(LAST_LIM);
  assign go_half  = ({1'b0, cnt_i} + (CW+1)'(1)) >> 1;
  assign go_words = go_last ? WC_W'(go_half) : WC_W'(CHUNK_WORDS);

  assign run_o      = state_q == SEQ_RUN;
  assign we_o       = run_o && wr_q && (rem_q != '0);
  assign done_o     = run_o && (!wr_q || rem_q == '0);
  assign last_o     = last_q;
  assign words_o    = words_q;
  assign src_addr_o = src_q;
  assign waddr_o    = off_q;
  assign wdata_o    = {buf_hi_i, buf_lo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      rem_q     <= '0;
      words_q   <= '0;
      last_q    <= 1'b0;
      stride4_q <= 1'b0;
      wr_q      <= 1'b0;
      src_q     <= '0;
      off_q     <= '0;
    end else if (abort_i) begin
      state_q <= SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (go_i) begin
          state_q   <= SEQ_RUN;
          rem_q     <= go_words;
          words_q   <= go_words;
          last_q    <= go_last;
          stride4_q <= stride4_i;
          wr_q      <= wr_en_i;
          src_q     <= src_i;
          off_q     <= base_off_i;
        end
        SEQ_RUN: begin
          if (we_o) begin
            rem_q <= rem_q - WC_W'(1);
            src_q <= src_q + AW'(2);
            off_q <= off_q + (stride4_q ? OFF_W'(4) : OFF_W'(2));
          end
          if (done_o) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  p_done_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !run_o);
  p_word_per_clk_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o && $past(we_o) |-> src_q == $past(src_q) + AW'(2));
  p_chunk_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> words_q <= WC_W'(CHUNK_WORDS));
endmodule

// File: rtl/cdx_end_ctrl.sv
module cdx_end_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       end_i,
  input  logic       abort_i,
  input  logic       ack_i,
  input  logic       irq_en_i,
  input  logic       mask_i,
  output logic       end_flag_o,
  output logic       data_rdy_o,
  output logic [7:0] if_stat_o,
  output logic       irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_flag_o <= 1'b0;
      data_rdy_o <= 1'b0;
      if_stat_o  <= 8'hFF;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= end_i && irq_en_i && mask_i;
      if (ack_i) if_stat_o[6] <= 1'b1;
      if (start_i) begin
        end_flag_o   <= 1'b0;
        data_rdy_o   <= 1'b1;
        if_stat_o[3] <= 1'b0;
      end
      if (abort_i) if_stat_o[3] <= 1'b1;
      // end overrides a same-cycle acknowledge
      if (end_i) begin
        end_flag_o   <= 1'b1;
        data_rdy_o   <= 1'b0;
        if_stat_o[3] <= 1'b1;
        if (irq_en_i) if_stat_o[6] <= 1'b0;
      end
    end
  end

  p_end_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> end_flag_o && !data_rdy_o && if_stat_o[3]);
  p_irq_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(end_i && irq_en_i && mask_i));
  p_end_beats_ack_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i && irq_en_i |=> !if_stat_o[6]);
endmodule

// File: rtl/cdx_xfer_engine.sv
module cdx_xfer_engine
  import cdx_xfer_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CW          = 16,
  parameter int DMA_AW      = 16,
  parameter int OFF_W       = 20,
  parameter int CHUNK_WORDS = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_en_i,
  input  logic              start_i,
  input  logic [AW-1:0]     start_addr_i,
  input  logic [CW-1:0]     start_cnt_i,
  input  logic [2:0]        dest_sel_i,
  input  logic [DMA_AW-1:0] dma_addr_i,
  input  logic              ram_1m_i,
  input  logic              bank_i,
  input  logic              end_irq_en_i,
  input  logic              irq_mask_i,
  input  logic              irq_ack_i,
  input  logic              host_rd_i,
  input  logic              host_is_sub_i,
  output logic [15:0]       host_data_o,
  input  logic              dma_go_i,
  output logic              dma_done_o,
  output logic [AW-1:0]     buf_addr_o,
  input  logic [7:0]        buf_hi_i,
  input  logic [7:0]        buf_lo_i,
  output logic              dst_we_o,
  output logic [OFF_W-1:0]  dst_addr_o,
  output logic [15:0]       dst_data_o,
  output logic              busy_o,
  output logic [AW-1:0]     xfer_addr_o,
  output logic [CW-1:0]     xfer_cnt_o,
  output logic              end_flag_o,
  output logic              data_rdy_o,
  output logic [7:0]        if_stat_o,
  output logic              irq_o
);
  localparam int WC_W = $clog2(CHUNK_WORDS + 1);

  logic [AW-1:0]    addr_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q;

  logic [OFF_W-1:0] map_base;
  logic             map_stride4, map_wr;
  logic             seq_run, seq_last, seq_done;
  logic [WC_W-1:0]  seq_words;
  logic [AW-1:0]    seq_src;

  logic abort_evt, start_evt, host_ok, host_last, dma_go, dma_fin, end_evt;
  logic dest_match;

  assign abort_evt  = busy_q && !xfer_en_i;
  assign start_evt  = start_i && xfer_en_i && !seq_run;
  assign dest_match = host_is_sub_i ? (dest_sel_i == DST_SUB) : (dest_sel_i == DST_MAIN);
  assign host_ok    = host_rd_i && busy_q && xfer_en_i && !seq_run && !start_i && dest_match;
  assign host_last  = cnt_q <= CW'(2);
  assign dma_go     = dma_go_i && busy_q && xfer_en_i && !seq_run && !start_i;
  assign dma_fin    = seq_done && !abort_evt;
  assign end_evt    = (host_ok && host_last) || (dma_fin && seq_last);

  cdx_dest_map #(.DMA_AW(DMA_AW), .OFF_W(OFF_W)) u_map (
    .dest_sel_i (dest_sel_i),
    .ram_1m_i   (ram_1m_i),
    .bank_i     (bank_i),
    .dma_addr_i (dma_addr_i),
    .base_off_o (map_base),
    .stride4_o  (map_stride4),
    .wr_en_o    (map_wr)
  );

  cdx_dma_seq #(.AW(AW), .CW(CW), .OFF_W(OFF_W), .CHUNK_WORDS(CHUNK_WORDS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (dma_go),
    .abort_i    (abort_evt),
    .cnt_i      (cnt_q),
    .src_i      (addr_q),
    .base_off_i (map_base),
    .stride4_i  (map_stride4),
    .wr_en_i    (map_wr),
    .buf_hi_i   (buf_hi_i),
    .buf_lo_i   (buf_lo_i),
    .run_o      (seq_run),
    .last_o     (seq_last),
    .words_o    (seq_words),
    .src_addr_o (seq_src),
    .we_o       (dst_we_o),
    .waddr_o    (dst_addr_o),
    .wdata_o    (dst_data_o),
    .done_o     (seq_done)
  );

  cdx_end_ctrl u_end (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_evt),
    .end_i      (end_evt),
    .abort_i    (abort_evt),
    .ack_i      (irq_ack_i),
    .irq_en_i   (end_irq_en_i),
    .mask_i     (irq_mask_i),
    .end_flag_o (end_flag_o),
    .data_rdy_o (data_rdy_o),
    .if_stat_o  (if_stat_o),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      cnt_q       <= '0;
      busy_q      <= 1'b0;
      host_data_o <= '0;
    end else begin
      if (host_rd_i) host_data_o <= host_ok ? {buf_hi_i, buf_lo_i} : 16'h0000;
      if (abort_evt) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start_evt) begin
        addr_q <= start_addr_i;
        cnt_q  <= start_cnt_i;
        busy_q <= 1'b1;
      end else if (host_ok) begin
        addr_q <= addr_q + AW'(2);
        cnt_q  <= host_last ? '0 : cnt_q - CW'(2);
        if (host_last) busy_q <= 1'b0;
      end else if (dma_fin) begin
        addr_q <= addr_q + AW'({seq_words, 1'b0});
        cnt_q  <= seq_last ? '0 : cnt_q - CW'({seq_words, 1'b0});
        busy_q <= !seq_last;
      end
    end
  end

  assign buf_addr_o  = seq_run ? seq_src : addr_q;
  assign dma_done_o  = seq_done;
  assign busy_o      = busy_q;
  assign xfer_addr_o = addr_q;
  assign xfer_cnt_o  = cnt_q;

  p_idle_cnt_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> cnt_q == '0);
  p_reject_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !busy_q && !start_i |=> host_data_o == 16'h0000 && addr_q == $past(addr_q));
  p_no_host_in_dma_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && seq_run |=> host_data_o == 16'h0000);
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && xfer_en_i && !seq_run |=> busy_q);
endmodule

// File: tb/cdx_xfer_engine_tb.sv
module cdx_xfer_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        xfer_en = 0, start = 0, ram_1m = 0, bank = 0;
  logic [15:0] start_addr = 0, start_cnt = 0, dma_addr = 0;
  logic [2:0]  dest_sel = 0;
  logic        end_irq_en = 0, irq_mask = 0, irq_ack = 0;
  logic        host_rd = 0, host_is_sub = 0, dma_go = 0;
  logic [15:0] host_data, buf_addr, xfer_addr, xfer_cnt, dst_data;
  logic [7:0]  buf_hi, buf_lo, if_stat;
  logic        dma_done, dst_we, busy, end_flag, data_rdy, irq;
  logic [19:0] dst_addr;

  int n_vec = 0, n_err = 0, cyc = 0;

  function automatic logic [7:0] bf(input logic [15:0] a);
    return a[7:0] * 8'd3 + a[15:8] + 8'h17;
  endfunction

  assign buf_hi = bf(buf_addr);
  assign buf_lo = bf(buf_addr + 16'd1);

  cdx_xfer_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .xfer_en_i(xfer_en), .start_i(start),
    .start_addr_i(start_addr), .start_cnt_i(start_cnt), .dest_sel_i(dest_sel),
    .dma_addr_i(dma_addr), .ram_1m_i(ram_1m), .bank_i(bank),
    .end_irq_en_i(end_irq_en), .irq_mask_i(irq_mask), .irq_ack_i(irq_ack),
    .host_rd_i(host_rd), .host_is_sub_i(host_is_sub), .host_data_o(host_data),
    .dma_go_i(dma_go), .dma_done_o(dma_done), .buf_addr_o(buf_addr),
    .buf_hi_i(buf_hi), .buf_lo_i(buf_lo), .dst_we_o(dst_we), .dst_addr_o(dst_addr),
    .dst_data_o(dst_data), .busy_o(busy), .xfer_addr_o(xfer_addr), .xfer_cnt_o(xfer_cnt),
    .end_flag_o(end_flag), .data_rdy_o(data_rdy), .if_stat_o(if_stat), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL R12 watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
    end
  end

  // DMA write monitor
  logic [19:0] exp_base = 0;
  int          exp_stride = 2;
  logic [15:0] exp_src = 0;
  int          wr_k = 0;
  always @(negedge clk) begin
    if (rst_n && dst_we) begin
      logic [19:0] ea;
      logic [15:0] es;
      ea = exp_base + 20'(wr_k * exp_stride);
      es = exp_src + 16'(2 * wr_k);
      chk("R9/R10 dst address", 32'(dst_addr), 32'(ea));
      chk("R3 dma word packing", 32'(dst_data), {16'h0, bf(es), bf(es + 16'd1)});
      wr_k++;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_start(input logic [15:0] a, input logic [15:0] c);
    start_addr = a; start_cnt = c; start = 1;
    tick();
    start = 0;
  endtask

  task automatic host_read(input logic sub);
    host_rd = 1; host_is_sub = sub;
    tick();
    host_rd = 0;
  endtask

  logic [15:0] ma, mc;

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    // R1
    chk("R1 busy", 32'(busy), 0);
    chk("R1 cnt", 32'(xfer_cnt), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 end_flag", 32'(end_flag), 0);
    chk("R1 data_rdy", 32'(data_rdy), 0);
    chk("R1 if_stat", 32'(if_stat), 32'hFF);
    chk("R1 dst_we", 32'(dst_we), 0);
    chk("R1 host_data", 32'(host_data), 0);

    // R2: start ignored when disabled
    do_start(16'h0300, 16'd4);
    chk("R2 start ignored busy", 32'(busy), 0);
    chk("R2 start ignored addr", 32'(xfer_addr), 0);

    // R2/R3/R5/R6 host reads, sub processor
    xfer_en = 1; dest_sel = 3; end_irq_en = 1; irq_mask = 1;
    do_start(16'h0010, 16'd9);
    chk("R2 busy", 32'(busy), 1);
    chk("R2 data_rdy", 32'(data_rdy), 1);
    chk("R2 end_flag", 32'(end_flag), 0);
    chk("R2 if_stat3", 32'(if_stat[3]), 0);
    chk("R2 cnt", 32'(xfer_cnt), 9);
    ma = 16'h0010; mc = 16'd9;
    for (int i = 0; i < 5; i++) begin
      logic lst;
      logic [15:0] ew;
      lst = mc <= 2;
      ew = {bf(ma), bf(ma + 16'd1)};
      host_read(1);
      ma = ma + 16'd2; mc = lst ? 16'd0 : mc - 16'd2;
      chk("R3 host word", 32'(host_data), 32'(ew));
      chk("R3 host addr", 32'(xfer_addr), 32'(ma));
      chk("R5 host cnt", 32'(xfer_cnt), 32'(mc));
      chk("R5 busy", 32'(busy), lst ? 0 : 1);
      chk("R6 irq", 32'(irq), lst ? 1 : 0);
    end
    chk("R6 end_flag", 32'(end_flag), 1);
    chk("R6 data_rdy", 32'(data_rdy), 0);
    chk("R6 if_stat3", 32'(if_stat[3]), 1);
    chk("R6 if_stat6", 32'(if_stat[6]), 0);
    tick();
    chk("R6 irq pulse", 32'(irq), 0);
    irq_ack = 1; tick(); irq_ack = 0;
    chk("R13 ack sets", 32'(if_stat[6]), 1);

    // R4 acceptance rules
    do_start(16'h0200, 16'd8);
    host_read(0);
    chk("R4 main on sub code data", 32'(host_data), 0);
    chk("R4 main on sub code addr", 32'(xfer_addr), 32'h0200);
    chk("R4 main on sub code cnt", 32'(xfer_cnt), 8);
    dest_sel = 2;
    host_read(0);
    chk("R4 main accepted", 32'(host_data), {16'h0, bf(16'h0200), bf(16'h0201)});
    chk("R4 main addr", 32'(xfer_addr), 32'h0202);
    host_read(1);
    chk("R4 sub on main code", 32'(host_data), 0);
    chk("R4 sub on main code cnt", 32'(xfer_cnt), 6);

    // R14 abort
    xfer_en = 0; tick();
    chk("R14 busy", 32'(busy), 0);
    chk("R14 cnt", 32'(xfer_cnt), 0);
    chk("R14 if_stat3", 32'(if_stat[3]), 1);
    chk("R14 end_flag", 32'(end_flag), 0);
    chk("R14 irq", 32'(irq), 0);
    host_read(0);
    chk("R4 idle reject", 32'(host_data), 0);
    chk("R4 idle addr", 32'(xfer_addr), 32'h0202);

    // R3 wrap
    xfer_en = 1; dest_sel = 3;
    do_start(16'hFFFF, 16'd4);
    host_read(1);
    chk("R3 wrap word", 32'(host_data), {16'h0, bf(16'hFFFF), bf(16'h0000)});
    chk("R3 wrap addr", 32'(xfer_addr), 32'h0001);
    chk("R5 cnt 2", 32'(xfer_cnt), 2);
    host_read(1);
    chk("R5 end at 2", 32'(busy), 0);
    irq_ack = 1; tick(); irq_ack = 0;

    // R13 ack and end in same cycle
    do_start(16'h0040, 16'd2);
    irq_ack = 1; host_read(1); irq_ack = 0;
    chk("R13 end beats ack", 32'(if_stat[6]), 0);
    chk("R13 irq", 32'(irq), 1);
    irq_ack = 1; tick(); irq_ack = 0;
    chk("R13 lone ack", 32'(if_stat[6]), 1);

    // R6 masked, then disabled
    irq_mask = 0;
    do_start(16'h0050, 16'd1);
    host_read(1);
    chk("R6 masked irq", 32'(irq), 0);
    chk("R6 masked if_stat6", 32'(if_stat[6]), 0);
    irq_ack = 1; tick(); irq_ack = 0;
    end_irq_en = 0; irq_mask = 1;
    do_start(16'h0060, 16'd1);
    host_read(1);
    chk("R6 disabled irq", 32'(irq), 0);
    chk("R6 disabled if_stat6", 32'(if_stat[6]), 1);

    // DMA sweep R7..R12
    for (int cfg = 0; cfg < 6; cfg++) begin
      for (int ci = 0; ci < 9; ci++) begin
        logic [15:0] cnts [9];
        logic [15:0] sa;
        logic        wrd;
        int          steps;
        cnts = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd511, 16'd512, 16'd513, 16'd1000, 16'd1025};
        case (cfg)
          0: begin dest_sel = 5; ram_1m = 0; bank = 0; end
          1: begin dest_sel = 7; ram_1m = 0; bank = 0; end
          2: begin dest_sel = 7; ram_1m = 1; bank = 0; end
          3: begin dest_sel = 7; ram_1m = 1; bank = 1; end
          4: begin dest_sel = 4; ram_1m = 0; bank = 0; end
          default: begin dest_sel = 0; ram_1m = 0; bank = 0; end
        endcase
        dma_addr = cfg[0] ? 16'hFFFF : 16'h1234;
        wrd = (cfg < 4);
        sa = 16'hFF00 + 16'(cfg * 16 + ci);
        do_start(sa, cnts[ci]);
        ma = sa; mc = cnts[ci];
        steps = 0;
        while (busy && steps < 10) begin
          logic lst;
          int w, cycles;
          lst = mc <= 512;
          w = lst ? (int'(mc) + 1) >> 1 : 256;
          if (cfg == 0) begin exp_base = {dma_addr, 3'b000} + 20'h0; exp_stride = 2; end
          else if (cfg == 1) begin exp_base = 20'(dma_addr & 16'h7FFF) << 3; exp_stride = 2; end
          else begin
            exp_base = (20'(dma_addr & 16'h3FFF) << 4) + (bank ? 20'd0 : 20'd2);
            exp_stride = 4;
          end
          exp_src = ma; wr_k = 0;
          dma_go = 1; tick(); dma_go = 0;
          cycles = 0;
          while (dma_done !== 1'b1 && cycles < 400) begin tick(); cycles++; end
          chk("R12 cycles to done", 32'(cycles), wrd ? 32'(w) : 0);
          tick();
          chk(wrd ? "R7 words written" : "R11 no writes", 32'(wr_k), wrd ? 32'(w) : 0);
          ma = ma + 16'(2 * w);
          mc = lst ? 16'd0 : mc - 16'(2 * w);
          chk("R8 addr", 32'(xfer_addr), 32'(ma));
          chk("R8 cnt", 32'(xfer_cnt), 32'(mc));
          chk("R7 busy after step", 32'(busy), lst ? 0 : 1);
          steps++;
        end
        chk("R7 step count", 32'(steps),
            (cnts[ci] <= 512) ? 1 : 32'((int'(cnts[ci]) - 512 + 511) / 512 + 1));
        chk("R6 dma end_flag", 32'(end_flag), 1);
        chk("R6 dma data_rdy", 32'(data_rdy), 0);
        chk("R6 dma if_stat3", 32'(if_stat[3]), 1);
        chk("R6 dma if_stat6", 32'(if_stat[6]), 1);
      end
    end
    summary();
  end
endmodule